// File: doc/BRIEF.md
# Fractional-Divider Baud Tick Generator

This block turns a module clock into the 16x oversampling tick that an asynchronous serial port uses to sample and shift its bits. The clock passes through two stages. A 9-bit fractional stage first thins the clock to a ratio of `frac_val/512`. A reload down-counter then divides those thinned pulses by `reload+1`. The result is a bit rate of `(frac_val/512) * f_clk / (16 * (reload+1))`. A fraction of 0, or a cleared fraction enable, passes the clock at full rate.

Software programs the generator in a fixed order. It clears `run`, writes the fraction and the reload value, then sets `run` again. The reload register ignores writes while `run` is high. While `run` is low, both stages are held at their start state. No data stream passes through the block, so every pin is a plain control or status signal.

Top module: `bgen_fracdiv_top`

## Requirements
- R1: After reset `tick` is low, the stored reload value is 0, and both stages are at their start state.
- R2: When `frac_en` is 0 or `frac_val` is 0, every clock with `run` high is a counting step. The first `tick` follows the (reload+1)-th running clock edge, and the next ones follow every reload+1 edges after it.
- R3: When `frac_en` is 1 and `frac_val` is nonzero, the first n running clock edges give floor(n*frac_val/512) counting steps. There is one `tick` per reload+1 steps, so n running edges give floor(floor(n*frac_val/512)/(reload+1)) ticks.
- R4: `tick` is a single-cycle pulse whenever the stored reload value is nonzero.
- R5: While `run` is low, `tick` stays low and both stages are held at their start state. A fresh start after a stop counts from the beginning, as in R2 and R3.
- R6: A pulse on `reload_wr` while `run` is high is ignored, and the stored reload value is unchanged.
- R7: A pulse on `reload_wr` while `run` is low stores `reload_data`, which sets the tick period from the next start.
- R8: `frac_val` is 9 bits wide, and the full-scale ratio is 512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Generator run control; low holds and unlocks the reload register |
| frac_en | input | 1 | Enables the fractional stage; 0 passes the clock at full rate |
| frac_val | input | 9 | Fraction numerator over 512; 0 means full rate |
| reload_wr | input | 1 | Single-cycle reload register write strobe |
| reload_data | input | 16 | Reload value to store |
| tick | output | 1 | 16x oversampling tick, one clock wide |

## Verification
Directed windows cover full-rate counting with reload 0 and 3, which fixes the position of the first tick. They also cover a 1/2 fraction and a nonzero fraction with the enable cleared, which separates the bypass from the fractional path. A write issued during a running window shows through the tick count, which stays at the old period, both inside that window and after a restart. A write made while stopped must then change the count. Random windows mix fractions, enables and reload values and compare the number of ticks with the closed-form count. This catches both a wrong carry rule and a wrong divide-by-(reload+1).

// File: rtl/bgen_pkg.sv
package bgen_pkg;
  parameter int FRAC_W   = 9;
  parameter int RELOAD_W = 16;
  localparam int FRAC_FULL = 1 << FRAC_W;
endpackage

// File: rtl/bgen_frac_stage.sv
module bgen_frac_stage #(
  parameter int FRAC_W = bgen_pkg::FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              frac_en,
  input  logic [FRAC_W-1:0] frac_val,
  output logic              step,
  output logic [FRAC_W-1:0] acc_q
);
  logic [FRAC_W:0] sum;
  logic            bypass;

  assign sum    = {1'b0, acc_q} + {1'b0, frac_val};
  assign bypass = !frac_en || (frac_val == '0);
  assign step   = run && (bypass || sum[FRAC_W]);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      acc_q <= '0;
    end else if (!bypass) begin
      acc_q <= sum[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/bgen_reload_ctr.sv
module bgen_reload_ctr #(
  parameter int RELOAD_W = bgen_pkg::RELOAD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                step,
  input  logic                wr,
  input  logic [RELOAD_W-1:0] wr_data,
  output logic                tick,
  output logic [RELOAD_W-1:0] cnt_q,
  output logic [RELOAD_W-1:0] reload_q
);
  logic wr_ok;
  assign wr_ok = wr && !run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
    end else if (wr_ok) begin
      reload_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (!run) begin
      cnt_q <= wr_ok ? wr_data : reload_q;
      tick  <= 1'b0;
    end else if (step) begin
      if (cnt_q == '0) begin
        cnt_q <= reload_q;
        tick  <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
        tick  <= 1'b0;
      end
    end else begin
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/bgen_fracdiv_top.sv
module bgen_fracdiv_top #(
  parameter int FRAC_W   = bgen_pkg::FRAC_W,
  parameter int RELOAD_W = bgen_pkg::RELOAD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                frac_en,
  input  logic [FRAC_W-1:0]   frac_val,
  input  logic                reload_wr,
  input  logic [RELOAD_W-1:0] reload_data,
  output logic                tick
);
  logic                step;
  logic [FRAC_W-1:0]   acc_w;
  logic [RELOAD_W-1:0] cnt_w;
  logic [RELOAD_W-1:0] reload_w;

  bgen_frac_stage #(.FRAC_W(FRAC_W)) u_frac (
    .clk(clk), .rst_n(rst_n), .run(run), .frac_en(frac_en),
    .frac_val(frac_val), .step(step), .acc_q(acc_w)
  );

  bgen_reload_ctr #(.RELOAD_W(RELOAD_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .run(run), .step(step),
    .wr(reload_wr), .wr_data(reload_data), .tick(tick),
    .cnt_q(cnt_w), .reload_q(reload_w)
  );
endmodule

// File: rtl/bgen_fracdiv_chk.sv
module bgen_fracdiv_chk #(
  parameter int FRAC_W   = bgen_pkg::FRAC_W,
  parameter int RELOAD_W = bgen_pkg::RELOAD_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic                run,
  input logic                frac_en,
  input logic [FRAC_W-1:0]   frac_val,
  input logic                step,
  input logic                tick,
  input logic [FRAC_W-1:0]   acc_w,
  input logic [RELOAD_W-1:0] cnt_w,
  input logic [RELOAD_W-1:0] reload_w
);
  // R5
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tick);
  // R5
  stop_acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (acc_w == '0));
  // R6
  reload_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(reload_w));
  // R2
  full_rate_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (!frac_en || frac_val == '0)) |-> step);
  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && reload_w != '0) |=> !tick);
  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_w <= reload_w));
endmodule

bind bgen_fracdiv_top bgen_fracdiv_chk #(.FRAC_W(FRAC_W), .RELOAD_W(RELOAD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .frac_en(frac_en), .frac_val(frac_val),
  .step(step), .tick(tick), .acc_w(acc_w), .cnt_w(cnt_w), .reload_w(reload_w)
);

// File: tb/bgen_fracdiv_top_tb_top.sv
module bgen_fracdiv_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        frac_en = 1'b0;
  logic [8:0]  frac_val = '0;
  logic        reload_wr = 1'b0;
  logic [15:0] reload_data = '0;
  logic        tick;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bgen_fracdiv_top dut_i (
    .clk(clk), .rst_n(rst_n), .run(run), .frac_en(frac_en),
    .frac_val(frac_val), .reload_wr(reload_wr), .reload_data(reload_data),
    .tick(tick)
  );

  function automatic int exp_ticks(int n, int f, bit fe, int r);
    int steps;
    steps = (!fe || f == 0) ? n : (n * f) / 512;
    return steps / (r + 1);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_reload(int r);
    @(negedge clk);
    run = 1'b0;
    reload_wr = 1'b1;
    reload_data = 16'(r);
    @(negedge clk);
    reload_wr = 1'b0;
    @(negedge clk);
  endtask

  // runs n edges with run high, counts ticks; returns first tick index and doubles
  task automatic run_window(int n, int wr_at, int wr_val,
                            output int cnt, output int first, output int dbl);
    bit prev;
    prev = 1'b0;
    cnt = 0; first = -1; dbl = 0;
    @(negedge clk);
    run = 1'b1;
    for (int i = 1; i <= n; i++) begin
      if (i == wr_at) begin reload_wr = 1'b1; reload_data = 16'(wr_val); end
      @(negedge clk);
      reload_wr = 1'b0;
      if (tick) begin
        cnt++;
        if (first < 0) first = i;
        if (prev) dbl++;
      end
      prev = tick;
    end
    run = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int c, f1, d, r, f, n, qs;
    bit fe;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1
    check("R1 tick after reset", int'(tick), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 tick after release", int'(tick), 0);
    // R1: stored reload 0 -> full rate tick every edge
    frac_en = 1'b0;
    run_window(10, 0, 0, c, f1, d);
    check("R1 default reload ticks", c, 10);

    // R2 directed, reload 3
    write_reload(3);
    run_window(40, 0, 0, c, f1, d);
    check("R2 first tick edge", f1, 4);
    check("R2 tick count", c, 10);
    // R4
    check("R4 no back-to-back ticks", d, 0);

    // R8 / R3 half fraction, reload 0
    write_reload(0);
    frac_en = 1'b1; frac_val = 9'd256;
    run_window(64, 0, 0, c, f1, d);
    check("R3 half fraction count", c, 32);
    check("R8 half fraction first tick", f1, 2);
    // R2 enable cleared with nonzero fraction
    frac_en = 1'b0; frac_val = 9'd100;
    write_reload(4);
    run_window(50, 0, 0, c, f1, d);
    check("R2 bypass with fraction loaded", c, 10);
    // R8 fraction 0 with enable means full rate
    frac_en = 1'b1; frac_val = 9'd0;
    run_window(50, 0, 0, c, f1, d);
    check("R8 zero fraction full rate", c, 10);

    // R6 write while running ignored
    frac_en = 1'b0;
    write_reload(2);
    run_window(60, 10, 7, c, f1, d);
    check("R6 period kept in window", c, 20);
    run_window(30, 0, 0, c, f1, d);
    check("R6 period kept after restart", c, 10);
    // R7 write while stopped applies
    write_reload(5);
    run_window(60, 0, 0, c, f1, d);
    check("R7 new period", c, 10);

    // R5 stopped: no ticks; restart counts from start
    qs = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (tick) qs++; end
    check("R5 no tick while stopped", qs, 0);
    frac_en = 1'b1; frac_val = 9'd300;
    write_reload(1);
    run_window(7, 0, 0, c, f1, d);
    run_window(20, 0, 0, c, f1, d);
    check("R5 restart from start", c, exp_ticks(20, 300, 1'b1, 1));

    // R3 random
    for (int k = 0; k < 24; k++) begin
      f  = int'($urandom_range(511, 0));
      fe = 1'($urandom_range(1, 0));
      r  = int'($urandom_range(20, 0));
      n  = int'($urandom_range(400, 50));
      frac_en = fe; frac_val = 9'(f);
      write_reload(r);
      run_window(n, 0, 0, c, f1, d);
      check("R3 random window", c, exp_ticks(n, f, fe, r));
      if (r != 0) check("R4 random single pulse", d, 0);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule